// File: doc/BRIEF.md
# Translation Buffer Invalidation Engine

This block holds a small unified address-translation buffer and runs maintenance writes against it. Each entry stores a valid flag, a lock flag, a global flag, an address-space identifier (ASID), a 20-bit virtual page tag and a two-bit page-size code. A requester presents a coprocessor-style maintenance access in a single cycle. The access carries the direction, the privilege mode, four selector fields and a 32-bit data word. The block checks and decodes the access, then clears entries according to one of three rules.

Two of the invalidations finish in a single cycle. Clearing by ASID walks the array one entry per cycle. An interrupt that arrives during that walk aborts it and reports that the operation did not execute. Software then reissues the operation, and the reissued walk starts again from entry 0.

A load port writes whole entries, standing in for the page-table walker. A peek port shows the valid flag of one entry, so that tests can watch the array.

Top module: `tlb_inval_engine`

## Requirements
- R1: After reset, every entry is invalid and req_ack, req_undef, sweep_aborted and pf_flush are all low.
- R2: A read access (req_write=0) or a user-mode access (req_priv=0) raises req_undef for one cycle, in the cycle after the request. It gives no req_ack and leaves every entry unchanged.
- R3: Any of the following is a decode fault: req_opc1 not 0, req_crn not 8, req_crm outside 5..7, or req_opc2 above 2. A decode fault raises req_undef in the same way as R2 and changes nothing.
- R4: req_crm values 5, 6 and 7 are all accepted, and all three act on the same single array.
- R5: req_opc2=0 clears every valid entry whose lock flag is 0 and keeps locked entries. It ignores req_data. In the cycle after the request it raises req_ack and pf_flush together, each for one cycle.
- R6: req_opc2=1 clears an entry when both of these hold: its tag matches the address, and either its ASID equals the supplied ASID or the entry is global. Lock flags do not prevent the clear. The tag comparison depends on the page-size code: 0 compares all 20 bits (4 KB), 1 compares tag bits [19:4] (64 KB), 2 compares tag bits [19:8] (1 MB), and 3 is treated like 0. req_ack rises in the cycle after the request, and pf_flush stays low.
- R7: req_opc2=2 clears every entry whose ASID matches, locked or not, and never clears a global entry. It checks entry k at the k-th clock edge after the request edge. req_ack rises exactly N_ENTRIES+1 cycles after the request.
- R8: An irq seen at a clock edge while the ASID walk is running stops the walk. In the next cycle sweep_aborted pulses and req_ack does not rise. Entries checked before the abort stay cleared. A later reissue walks again from entry 0 and also clears matching entries loaded in the meantime.
- R9: A request that arrives while the ASID walk is running is ignored: no req_undef, no pf_flush, and no effect on the entries.
- R10: The ASID argument is req_data[ASID_W-1:0] and the address argument is req_data[31:12]. Bits [11:ASID_W] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | One-cycle maintenance access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged mode |
| req_opc1 | input | 3 | First opcode selector |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_opc2 | input | 3 | Operation selector |
| req_data | input | 32 | Data word |
| req_ack | output | 1 | Operation completed (pulse) |
| req_undef | output | 1 | Undefined-access indication (pulse) |
| irq | input | 1 | Interrupt request |
| sweep_aborted | output | 1 | ASID walk aborted, not executed (pulse) |
| pf_flush | output | 1 | Prefetch flush request (pulse) |
| ld_en | input | 1 | Load an entry and mark it valid |
| ld_idx | input | IW | Entry index to load |
| ld_lock | input | 1 | Lock flag for the load |
| ld_global | input | 1 | Global flag for the load |
| ld_asid | input | ASID_W | ASID for the load |
| ld_vpn | input | 20 | Virtual page tag for the load |
| ld_size | input | 2 | Page-size code for the load |
| peek_idx | input | IW | Entry index to observe |
| peek_valid | output | 1 | Valid flag of the observed entry |

## Verification
The bench builds the block with N_ENTRIES=6. Because six is not a power of two, the walk has to stop on an index below the counter's natural wrap, and an off-by-one in the last-entry test or in the acknowledge delay shows up as a wrong cycle count. The bench draws ASIDs from a range of four values and page tags from a few clustered bases. This makes matches by ASID, by global flag and under each size mask common in the random traffic.

// File: rtl/tlb_inval_engine.sv
module tlb_inval_engine #(
  parameter int N_ENTRIES = 8,
  parameter int ASID_W = 8,
  localparam int IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic [2:0]        req_opc1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_opc2,
  input  logic [31:0]       req_data,
  output logic              req_ack,
  output logic              req_undef,
  input  logic              irq,
  output logic              sweep_aborted,
  output logic              pf_flush,
  input  logic              ld_en,
  input  logic [IW-1:0]     ld_idx,
  input  logic              ld_lock,
  input  logic              ld_global,
  input  logic [ASID_W-1:0] ld_asid,
  input  logic [19:0]       ld_vpn,
  input  logic [1:0]        ld_size,
  input  logic [IW-1:0]     peek_idx,
  output logic              peek_valid
);

  logic [N_ENTRIES-1:0] e_valid, e_lock, e_glob, kill;
  logic [ASID_W-1:0]    e_asid [N_ENTRIES];
  logic [19:0]          e_vpn  [N_ENTRIES];
  logic [1:0]           e_size [N_ENTRIES];

  logic              busy;
  logic [IW-1:0]     sw_idx;
  logic [ASID_W-1:0] sw_asid;

  wire accept = req_valid && !busy;
  wire legal  = req_write && req_priv && req_opc1 == 3'd0 && req_crn == 4'd8 &&
                req_crm >= 4'd5 && req_crm <= 4'd7 && req_opc2 <= 3'd2;
  wire do_all  = accept && legal && req_opc2 == 3'd0;
  wire do_va   = accept && legal && req_opc2 == 3'd1;
  wire do_asid = accept && legal && req_opc2 == 3'd2;

  wire [19:0]       va_arg   = req_data[31:12];
  wire [ASID_W-1:0] asid_arg = req_data[ASID_W-1:0];

  wire sweep_step = busy && !irq;
  wire sweep_last = sweep_step && sw_idx == IW'(N_ENTRIES - 1);

  always_comb begin
    for (int i = 0; i < N_ENTRIES; i++) begin
      logic [19:0] mask;
      mask = (e_size[i] == 2'd2) ? 20'hFFF00 :
             (e_size[i] == 2'd1) ? 20'hFFFF0 : 20'hFFFFF;
      kill[i] = (do_all && !e_lock[i]) ||
                (do_va && ((e_vpn[i] ^ va_arg) & mask) == 20'd0 &&
                 (e_glob[i] || e_asid[i] == asid_arg)) ||
                (sweep_step && sw_idx == IW'(i) && e_asid[i] == sw_asid && !e_glob[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_valid <= '0;
    else
      for (int i = 0; i < N_ENTRIES; i++)
        if (ld_en && ld_idx == IW'(i)) e_valid[i] <= 1'b1;
        else if (kill[i])              e_valid[i] <= 1'b0;
  end

  always_ff @(posedge clk)
    for (int i = 0; i < N_ENTRIES; i++)
      if (ld_en && ld_idx == IW'(i)) begin
        e_lock[i] <= ld_lock;
        e_glob[i] <= ld_global;
        e_asid[i] <= ld_asid;
        e_vpn[i]  <= ld_vpn;
        e_size[i] <= ld_size;
      end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sw_idx <= '0; sw_asid <= '0;
      req_ack <= 1'b0; req_undef <= 1'b0; sweep_aborted <= 1'b0; pf_flush <= 1'b0;
    end else begin
      req_ack       <= do_all || do_va || sweep_last;
      req_undef     <= accept && !legal;
      sweep_aborted <= busy && irq;
      pf_flush      <= do_all;
      if (do_asid) begin
        busy <= 1'b1; sw_idx <= '0; sw_asid <= asid_arg;
      end else if (busy && (irq || sweep_last)) begin
        busy <= 1'b0;
      end else if (sweep_step) begin
        sw_idx <= sw_idx + 1'b1;
      end
    end
  end

  assign peek_valid = e_valid[peek_idx];

  p_resp_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ack, req_undef, sweep_aborted}));
  p_undef_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_undef && !$past(ld_en) |-> $stable(e_valid));
  p_flush_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pf_flush |-> req_ack);
  p_busy_no_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ack);
  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> sw_idx <= IW'(N_ENTRIES - 1));
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_aborted |-> !busy && $past(irq));
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid |=> !req_undef && !pf_flush);

endmodule

// File: tb/tlb_inval_engine_tb_top.sv
module tlb_inval_engine_tb_top;
  localparam int N = 6;
  localparam int AW = 8;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_priv = 0;
  logic [2:0] req_opc1 = 0, req_opc2 = 0;
  logic [3:0] req_crn = 0, req_crm = 0;
  logic [31:0] req_data = 0;
  logic req_ack, req_undef, sweep_aborted, pf_flush, peek_valid;
  logic irq = 0, ld_en = 0, ld_lock = 0, ld_global = 0;
  logic [IW-1:0] ld_idx = 0, peek_idx = 0;
  logic [AW-1:0] ld_asid = 0;
  logic [19:0] ld_vpn = 0;
  logic [1:0] ld_size = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  bit        m_valid [N];
  bit        m_lock  [N];
  bit        m_glob  [N];
  bit [7:0]  m_asid  [N];
  bit [19:0] m_vpn   [N];
  bit [1:0]  m_size  [N];

  always #10 clk = ~clk;

  tlb_inval_engine #(.N_ENTRIES(N), .ASID_W(AW)) dut_i (
    .clk, .rst_n, .req_valid, .req_write, .req_priv, .req_opc1, .req_crn, .req_crm,
    .req_opc2, .req_data, .req_ack, .req_undef, .irq, .sweep_aborted, .pf_flush,
    .ld_en, .ld_idx, .ld_lock, .ld_global, .ld_asid, .ld_vpn, .ld_size,
    .peek_idx, .peek_valid);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  function automatic bit va_hit(int i, bit [31:0] d);
    bit [19:0] mask;
    mask = (m_size[i] == 2) ? 20'hFFF00 : (m_size[i] == 1) ? 20'hFFFF0 : 20'hFFFFF;
    return m_valid[i] && ((m_vpn[i] ^ d[31:12]) & mask) == 0 &&
           (m_glob[i] || m_asid[i] == d[7:0]);
  endfunction

  function automatic void apply(int op, bit [31:0] d, int upto);
    for (int i = 0; i < N; i++) begin
      if (op == 0 && !m_lock[i]) m_valid[i] = 0;
      if (op == 1 && va_hit(i, d)) m_valid[i] = 0;
      if (op == 2 && i < upto && m_asid[i] == d[7:0] && !m_glob[i]) m_valid[i] = 0;
    end
  endfunction

  task automatic check_array(string req);
    int bad = 0, want = 0, got = 0;
    for (int i = 0; i < N; i++) begin
      peek_idx = IW'(i);
      #1;
      if (peek_valid !== m_valid[i]) begin bad++; got = peek_valid; want = m_valid[i]; end
    end
    chk(bad == 0, req, got, want);
  endtask

  task automatic load(int i, bit lk, bit gl, bit [7:0] a, bit [19:0] v, bit [1:0] s);
    ld_en = 1; ld_idx = IW'(i); ld_lock = lk; ld_global = gl; ld_asid = a; ld_vpn = v; ld_size = s;
    tick();
    ld_en = 0;
    m_valid[i] = 1; m_lock[i] = lk; m_glob[i] = gl; m_asid[i] = a; m_vpn[i] = v; m_size[i] = s;
  endtask

  task automatic issue(bit w, bit p, bit [2:0] o1, bit [3:0] n, bit [3:0] m, bit [2:0] o2, bit [31:0] d);
    req_valid = 1; req_write = w; req_priv = p; req_opc1 = o1; req_crn = n; req_crm = m;
    req_opc2 = o2; req_data = d;
    tick();
    req_valid = 0;
  endtask

  task automatic run_op(int op, bit [3:0] m, bit [31:0] d, string req);
    issue(1, 1, 0, 8, m, 3'(op), d);
    chk(req_undef == 0, req, req_undef, 0);
    if (op != 2) begin
      chk(req_ack == 1, req, req_ack, 1);
      chk(pf_flush == (op == 0), req, pf_flush, op == 0);
      apply(op, d, N);
    end else begin
      for (int c = 1; c <= N; c++) begin
        if (c < N) chk(req_ack == 0, req, req_ack, 0);
        tick();
      end
      chk(req_ack == 1, req, req_ack, 1);
      apply(2, d, N);
    end
    check_array(req);
  endtask

  task automatic illegal(bit w, bit p, bit [2:0] o1, bit [3:0] n, bit [3:0] m, bit [2:0] o2, string req);
    issue(w, p, o1, n, m, o2, 32'h0);
    chk(req_undef == 1 && req_ack == 0, req, {req_undef, req_ack}, 2);
    check_array(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tick(); tick();
    rst_n = 1;
    tick();
    // R1
    chk(!req_ack && !req_undef && !sweep_aborted && !pf_flush, "R1", {req_ack, req_undef, sweep_aborted, pf_flush}, 0);
    check_array("R1");

    for (int i = 0; i < N; i++) load(i, i % 2, i == 5, 8'd3, 20'h12340 + 20'(i), 2'd0);
    // R2 and R3 illegal accesses leave the array intact
    illegal(0, 1, 0, 8, 7, 0, "R2 read");
    illegal(1, 0, 0, 8, 7, 0, "R2 user");
    illegal(1, 1, 1, 8, 7, 0, "R3 opc1");
    illegal(1, 1, 0, 7, 7, 0, "R3 crn");
    illegal(1, 1, 0, 8, 4, 0, "R3 crm");
    illegal(1, 1, 0, 8, 7, 3, "R3 opc2");

    // R5 unlocked invalidate, data ignored; R4 crm=5
    run_op(0, 5, 32'hFFFF_FFFF, "R5 R4");

    // R6 size masks and R10 argument fields
    load(0, 1, 0, 8'd7, 20'h12300, 2'd2);
    load(1, 0, 0, 8'd7, 20'h12345, 2'd0);
    load(2, 0, 0, 8'd7, 20'hABC10, 2'd1);
    load(3, 0, 1, 8'd9, 20'h55555, 2'd3);
    run_op(1, 6, {20'h123AB, 4'hF, 8'd7}, "R6 1MB R10");
    run_op(1, 7, {20'h12346, 4'h0, 8'd7}, "R6 4KB miss");
    run_op(1, 6, {20'hABC1F, 4'hA, 8'd7}, "R6 64KB");
    run_op(1, 5, {20'h55555, 4'h0, 8'd1}, "R6 global");

    // R7 ASID walk timing and rules
    for (int i = 0; i < N; i++) load(i, i == 1, i == 2, (i < 4) ? 8'd5 : 8'd6, 20'(i), 2'd0);
    run_op(2, 7, 32'h0000_0F05, "R7");

    // R8 abort then restart
    for (int i = 0; i < N; i++) load(i, 0, i == 4, 8'd5, 20'(i), 2'd0);
    issue(1, 1, 0, 8, 6, 2, 32'd5);
    tick(); tick();
    irq = 1;
    tick();
    irq = 0;
    chk(sweep_aborted == 1 && req_ack == 0, "R8 abort", {sweep_aborted, req_ack}, 2);
    apply(2, 32'd5, 2);
    check_array("R8 partial");
    load(0, 1, 0, 8'd5, 20'h777, 2'd0);
    load(1, 0, 0, 8'd5, 20'h778, 2'd0);
    run_op(2, 6, 32'd5, "R8 restart");

    // R9 requests while walking are ignored
    for (int i = 0; i < N; i++) load(i, 0, 0, (i < 2) ? 8'd1 : 8'd2, 20'(i), 2'd0);
    issue(1, 1, 0, 8, 7, 2, 32'd1);
    issue(1, 1, 0, 8, 7, 0, 32'd0);
    chk(pf_flush == 0 && req_undef == 0, "R9 legal", {pf_flush, req_undef}, 0);
    issue(1, 0, 0, 8, 7, 0, 32'd0);
    chk(req_undef == 0, "R9 illegal", req_undef, 0);
    for (int c = 3; c <= N; c++) tick();
    chk(req_ack == 1, "R9 ack", req_ack, 1);
    apply(2, 32'd1, N);
    check_array("R9");

    // random mix
    for (int it = 0; it < 80; it++) begin
      int r;
      bit [31:0] d;
      bit [3:0] m;
      for (int k = 0; k < 3; k++) begin
        bit [19:0] base;
        case ($urandom % 3) 0: base = 20'h00000; 1: base = 20'h00100; default: base = 20'h12300; endcase
        load($urandom % N, $urandom % 2, ($urandom % 4) == 0, 8'($urandom % 4),
             base + 20'($urandom % 32), 2'($urandom % 4));
      end
      r = $urandom % 8;
      m = 4'(5 + $urandom % 3);
      d = $urandom;
      d[7:0] = 8'($urandom % 4);
      if (r >= 2 && r <= 4) d[31:12] = m_vpn[$urandom % N] ^ 20'($urandom % 16);
      if (r < 2) run_op(0, m, d, "R5 R4 rnd");
      else if (r < 5) run_op(1, m, d, "R6 R10 rnd");
      else if (r < 7) run_op(2, m, d, "R7 rnd");
      else case ($urandom % 4)
        0: illegal(1, 0, 0, 8, m, 1, "R2 rnd");
        1: illegal(0, 1, 0, 8, m, 2, "R2 rnd");
        2: illegal(1, 1, 0, 8, m, 3'(3 + $urandom % 5), "R3 rnd");
        default: illegal(1, 1, 3'(1 + $urandom % 7), 8, m, 0, "R3 rnd");
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule